// File: doc/BRIEF.md
# Multi-Module Boost Power-State Controller

This block sequences power for a processor built from several compute modules of two cores each. On a fixed evaluation cadence it chooses one chip-wide performance level from a boost-enable input, the sum of the per-module power readings and a design power limit. It then gives every core its own 3-bit state code, so that an idle core can sink toward its lowest clock while its sibling keeps working.

A module whose two cores are both idle is put to sleep. The controller first asks the module's caches to write back to the shared last-level cache, using a request/acknowledge pair. Only after the acknowledge does it close the module's power gate. Load that returns before the acknowledge cancels the write-back. Load that returns while the module is gated opens the gate at once, but the cores get a clock only after a fixed number of evaluation periods has passed. The deepest boost level is granted only while at least half the modules are gated.

Each per-module sequencer has four named states. RUN means powered with a clock. FLUSH means the write-back request is up. SLEEP means gated. WAKE means the gate is open and the module is settling. Transitions happen only at evaluation boundaries:
- RUN->FLUSH when both cores are idle.
- FLUSH->RUN on load (abort).
- FLUSH->SLEEP on acknowledge.
- SLEEP->WAKE on load.
- WAKE->RUN after the settle count.

Core codes: 0 is max boost, 1 is all-module boost, 2 is base, 3 to 5 are the reduced states (5 is the 1400 MHz floor), and 6 is the gated deep-sleep state.

Top module: `boost_pstate_ctrl`

## Requirements
- R1: After reset every core code is 2, and no flush request or power gate is asserted.
- R2: With boost_en low, every busy core in a running module gets code 2, and no core is ever given a code below 2.
- R3: With boost_en high, summed module power below power_limit, and fewer than half the modules gated, busy cores in running modules get code 1.
- R4: With boost_en high, summed power below the limit, and at least half the modules gated, busy cores in running modules get code 0. Code 0 never appears while fewer than half the modules are gated.
- R5: When summed power reaches power_limit during boost, boosted cores return to code 2 within one evaluation period.
- R6: An idle core in a running module steps to 3, then 4, then 5, one step per evaluation, and holds at the floor code 5. A busy sibling keeps its own code.
- R7: A module with both cores idle raises flush_req at an evaluation. Its gate_en rises only at an evaluation where flush_ack is high and load is still absent. Both cores of a gated module show code 6.
- R8: If a core of a flushing module becomes busy before the acknowledge, flush_req drops at the next evaluation, the gate stays open, and the module runs again.
- R9: A gated module that sees load releases its gate at the next evaluation. Its cores stay at code 6 for exactly SETTLE_EVALS evaluation periods, and only then receive a running code.
- R10: Core codes change only in the clock after an evaluation boundary (every EVAL_PERIOD clocks from reset) and never exceed 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boost_en | input | 1 | Allows codes 1 and 0 |
| power_limit | input | PWR_W+clog2(NUM_MOD) | Design power limit |
| mod_power | input | NUM_MOD*PWR_W | Per-module power readings, module m at [m*PWR_W +: PWR_W] |
| core_busy | input | 2*NUM_MOD | Core load flags, cores 2m and 2m+1 belong to module m |
| flush_ack | input | NUM_MOD | Cache write-back done, per module |
| core_state | output | 6*NUM_MOD | 3-bit code per core, core i at [3i +: 3] |
| flush_req | output | NUM_MOD | Cache write-back request, per module |
| gate_en | output | NUM_MOD | Power gate closed, per module |

## Verification
The bench sweeps every one of the 256 load patterns under boost off, boost within the limit and boost over the limit. For each pattern it predicts the gated-module count, the chip level and every core code arithmetically. A design that counted modules wrongly for the half-gated rule would hand out code 0 or code 1 in the wrong patterns. The bench also checks directed corners:
- A load that returns before the acknowledge, where a broken abort would gate a busy module.
- The exact wake latency, where a short settle would clock cores before the rail is stable.
- The step-down sequence and its floor, which would be wrong if the step wrapped past 5 or jumped.
- Fallback timing after the power limit is crossed, which would be slow or absent.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
    typedef enum logic [1:0] {
        MS_RUN   = 2'd0,
        MS_FLUSH = 2'd1,
        MS_SLEEP = 2'd2,
        MS_WAKE  = 2'd3
    } mod_st_t;

    localparam logic [2:0] CODE_MAX   = 3'd0;
    localparam logic [2:0] CODE_BOOST = 3'd1;
    localparam logic [2:0] CODE_BASE  = 3'd2;
    localparam logic [2:0] CODE_LOW1  = 3'd3;
    localparam logic [2:0] CODE_DEEP  = 3'd6;
endpackage

// File: rtl/bpc_eval_timer.sv
module bpc_eval_timer #(
    parameter int EVAL_PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (EVAL_PERIOD > 1) ? $clog2(EVAL_PERIOD) : 1;
    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(EVAL_PERIOD - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/bpc_mod_fsm.sv
module bpc_mod_fsm
    import bpc_pkg::*;
#(
    parameter int SETTLE_EVALS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] busy,
    input  logic       flush_ack,
    output logic       flush_req,
    output logic       gate_en,
    output logic       run_next,
    output logic       asleep_next
);
    localparam int SW = $clog2(SETTLE_EVALS + 1);

    mod_st_t st_q, st_d;
    logic [SW-1:0] settle_q;
    logic any_busy;

    assign any_busy = |busy;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            unique case (st_q)
                MS_RUN:   if (!any_busy) st_d = MS_FLUSH;
                MS_FLUSH: if (any_busy) st_d = MS_RUN;
                          else if (flush_ack) st_d = MS_SLEEP;
                MS_SLEEP: if (any_busy) st_d = MS_WAKE;
                MS_WAKE:  if (settle_q == SW'(SETTLE_EVALS - 1)) st_d = MS_RUN;
                default:  st_d = MS_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= MS_RUN;
            settle_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q != MS_WAKE) settle_q <= '0;
            else if (tick)       settle_q <= settle_q + 1'b1;
        end
    end

    always_comb begin
        flush_req   = (st_q == MS_FLUSH);
        gate_en     = (st_q == MS_SLEEP);
        run_next    = (st_d == MS_RUN);
        asleep_next = (st_d == MS_SLEEP);
    end

    // R7
    gate_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> $past(flush_ack && !any_busy && tick));
    // R8
    abort_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MS_FLUSH && tick && any_busy) |=> (!gate_en && !flush_req));
endmodule

// File: rtl/bpc_core_pick.sv
module bpc_core_pick #(
    parameter logic [2:0] FLOOR_CODE = 3'd5
) (
    input  logic [2:0] level,
    input  logic       mod_run,
    input  logic       busy,
    input  logic [2:0] cur,
    output logic [2:0] nxt
);
    always_comb begin
        if (!mod_run)                       nxt = 3'd6;
        else if (busy)                      nxt = level;
        else if (cur < 3'd3 || cur == 3'd6) nxt = 3'd3;
        else if (cur < FLOOR_CODE)          nxt = cur + 3'd1;
        else                                nxt = FLOOR_CODE;
    end
endmodule

// File: rtl/boost_pstate_ctrl.sv
module boost_pstate_ctrl
    import bpc_pkg::*;
#(
    parameter int         NUM_MOD      = 4,
    parameter int         PWR_W        = 8,
    parameter int         EVAL_PERIOD  = 8,
    parameter int         SETTLE_EVALS = 2,
    parameter logic [2:0] FLOOR_CODE   = 3'd5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               boost_en,
    input  logic [PWR_W+$clog2(NUM_MOD)-1:0]   power_limit,
    input  logic [NUM_MOD*PWR_W-1:0]           mod_power,
    input  logic [2*NUM_MOD-1:0]               core_busy,
    input  logic [NUM_MOD-1:0]                 flush_ack,
    output logic [6*NUM_MOD-1:0]               core_state,
    output logic [NUM_MOD-1:0]                 flush_req,
    output logic [NUM_MOD-1:0]                 gate_en
);
    localparam int SUM_W = PWR_W + $clog2(NUM_MOD);
    localparam int NCORE = 2 * NUM_MOD;
    localparam int MC_W  = $clog2(NUM_MOD + 1);

    logic tick;
    logic [NUM_MOD-1:0] run_nx, sleep_nx;
    logic [SUM_W-1:0] pwr_sum;
    logic [MC_W-1:0] sleep_cnt;
    logic [2:0] level;
    logic [2:0] code_q [NCORE];
    logic [2:0] code_d [NCORE];

    bpc_eval_timer #(.EVAL_PERIOD(EVAL_PERIOD)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
        bpc_mod_fsm #(.SETTLE_EVALS(SETTLE_EVALS)) u_fsm (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .busy(core_busy[2*m +: 2]), .flush_ack(flush_ack[m]),
            .flush_req(flush_req[m]), .gate_en(gate_en[m]),
            .run_next(run_nx[m]), .asleep_next(sleep_nx[m]));
    end

    always_comb begin
        pwr_sum   = '0;
        sleep_cnt = '0;
        for (int m = 0; m < NUM_MOD; m++) begin
            pwr_sum   = pwr_sum + {{(SUM_W-PWR_W){1'b0}}, mod_power[m*PWR_W +: PWR_W]};
            sleep_cnt = sleep_cnt + MC_W'(sleep_nx[m]);
        end
    end

    always_comb begin
        if (!boost_en || pwr_sum >= power_limit) level = CODE_BASE;
        else if (2 * int'(sleep_cnt) >= NUM_MOD) level = CODE_MAX;
        else                                     level = CODE_BOOST;
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        bpc_core_pick #(.FLOOR_CODE(FLOOR_CODE)) u_pick (
            .level(level), .mod_run(run_nx[c/2]), .busy(core_busy[c]),
            .cur(code_q[c]), .nxt(code_d[c]));

        always_ff @(posedge clk) begin
            if (!rst_n)    code_q[c] <= CODE_BASE;
            else if (tick) code_q[c] <= code_d[c];
        end

        assign core_state[3*c +: 3] = code_q[c];

        // R7
        gated_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gate_en[c/2] |-> (core_state[3*c +: 3] == CODE_DEEP));
        // R2
        no_boost_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !boost_en) |=> (core_state[3*c +: 3] >= CODE_BASE));
        // R4
        max_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (core_state[3*c +: 3] == CODE_MAX) |-> (2 * $countones(gate_en) >= NUM_MOD));
        // R10
        code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            core_state[3*c +: 3] <= CODE_DEEP);
        // R10
        eval_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(tick) |-> $stable(core_state[3*c +: 3]));
    end
endmodule

// File: tb/sim_boost_pstate_ctrl.sv
module sim_boost_pstate_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NM = 4;
    localparam int PW = 8;
    localparam int EV = 8;
    localparam int ST = 2;
    localparam int NC = 2 * NM;
    localparam int SW = PW + $clog2(NM);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boost_en = 1'b0;
    logic [SW-1:0] power_limit = SW'(100);
    logic [NM*PW-1:0] mod_power = {NM{8'd10}};
    logic [NC-1:0] core_busy = '1;
    logic [NM-1:0] flush_ack;
    logic [6*NM-1:0] core_state;
    logic [NM-1:0] flush_req, gate_en;
    logic ack_en = 1'b1;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) flush_ack <= '0;
        else        flush_ack <= flush_req & {NM{ack_en}};
    end

    boost_pstate_ctrl #(.NUM_MOD(NM), .PWR_W(PW), .EVAL_PERIOD(EV),
                        .SETTLE_EVALS(ST), .FLOOR_CODE(3'd5)) u0 (
        .clk(clk), .rst_n(rst_n), .boost_en(boost_en), .power_limit(power_limit),
        .mod_power(mod_power), .core_busy(core_busy), .flush_ack(flush_ack),
        .core_state(core_state), .flush_req(flush_req), .gate_en(gate_en));

    function automatic int code_of(int i);
        return int'(core_state[3*i +: 3]);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        int sleeping, lvl, n;
        waitn(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int c = 0; c < NC; c++) chk("R1 code", code_of(c), 2);
        chk("R1 flush_req", int'(flush_req), 0);
        chk("R1 gate_en", int'(gate_en), 0);

        // exhaustive sweep: R2 R3 R4 R5 R6 R7
        for (int mode = 0; mode < 3; mode++) begin
            for (int p = 0; p < 256; p++) begin
                boost_en = (mode != 0);
                power_limit = (mode == 2) ? SW'(30) : SW'(100);
                core_busy = NC'(p);
                waitn(8 * EV + 2);
                sleeping = 0;
                for (int m = 0; m < NM; m++) if (((p >> (2*m)) & 3) == 0) sleeping++;
                if (mode != 1) lvl = 2;
                else lvl = (2 * sleeping >= NM) ? 0 : 1;
                for (int m = 0; m < NM; m++) begin
                    bit asleep;
                    asleep = (((p >> (2*m)) & 3) == 0);
                    chk("R7 gate", int'(gate_en[m]), int'(asleep));
                    for (int h = 0; h < 2; h++) begin
                        int c;
                        c = 2*m + h;
                        if (asleep) chk("R7 deep code", code_of(c), 6);
                        else if (((p >> c) & 1) == 0) chk("R6 idle floor", code_of(c), 5);
                        else if (mode == 0) chk("R2 base", code_of(c), 2);
                        else if (mode == 2) chk("R5 over limit", code_of(c), 2);
                        else if (lvl == 0) chk("R4 max boost", code_of(c), 0);
                        else chk("R3 boost", code_of(c), 1);
                    end
                end
                chk("R7 flush idle", int'(flush_req), 0);
            end
        end

        // R5 fallback timing
        boost_en = 1; power_limit = SW'(100); core_busy = '1;
        waitn(4 * EV);
        chk("R3 all busy boost", code_of(0), 1);
        power_limit = SW'(30);
        n = 0;
        while (code_of(0) != 2 && n < 4 * EV) begin @(negedge clk); n++; end
        chk("R5 fallback within period", int'(n >= 1 && n <= EV), 1);

        // R6 step sequence, R10 hold between evaluations
        boost_en = 0; core_busy = '1;
        waitn(4 * EV);
        core_busy[1] = 1'b0;
        n = 0;
        while (code_of(1) == 2 && n < 4 * EV) begin @(negedge clk); n++; end
        chk("R6 first step", code_of(1), 3);
        chk("R6 sibling kept", code_of(0), 2);
        n = 0;
        for (int k = 0; k < EV - 1; k++) begin @(negedge clk); if (code_of(1) != 3) n++; end
        chk("R10 held between evaluations", n, 0);
        @(negedge clk); chk("R6 second step", code_of(1), 4);
        waitn(EV); chk("R6 third step", code_of(1), 5);
        waitn(EV); chk("R6 floor hold", code_of(1), 5);

        // R8 abort before acknowledge
        core_busy = '1; ack_en = 0;
        waitn(4 * EV);
        core_busy[7:6] = 2'b00;
        n = 0;
        while (!flush_req[3] && n < 4 * EV) begin @(negedge clk); n++; end
        chk("R7 flush raised", int'(flush_req[3]), 1);
        waitn(2 * EV);
        chk("R7 no gate without ack", int'(gate_en[3]), 0);
        core_busy[6] = 1'b1;
        waitn(EV + 1);
        chk("R8 flush dropped", int'(flush_req[3]), 0);
        chk("R8 stays powered", int'(gate_en[3]), 0);
        chk("R8 busy core runs", code_of(6), 2);
        chk("R8 idle sibling steps", code_of(7), 3);

        // R9 wake settle
        ack_en = 1; core_busy[6] = 1'b0;
        n = 0;
        while (!gate_en[3] && n < 6 * EV) begin @(negedge clk); n++; end
        chk("R7 gated after ack", int'(gate_en[3]), 1);
        chk("R7 gated deep", code_of(6), 6);
        core_busy[6] = 1'b1;
        n = 0;
        while (gate_en[3] && n < 4 * EV) begin @(negedge clk); n++; end
        chk("R9 gate released within period", int'(n <= EV), 1);
        n = 0;
        while (code_of(6) == 6 && n < 8 * EV) begin @(negedge clk); n++; end
        chk("R9 settle length", n, ST * EV);
        chk("R9 running code", code_of(6), 2);

        finish_run();
    end
endmodule